// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block sits between a simple host request port and an asynchronous DRAM whose row and column addresses share one set of pins. For each accepted request it puts the row part of the address on the pins and lowers the active-low row strobe. After a row-to-column delay it puts the column part on the same pins and lowers the active-low column strobe. It then waits until the read data is valid under both access-time budgets, captures the data and pulses `done`. Every delay is a nanosecond parameter that is turned into clock cycles.

After an access the row stays open, with the row strobe held low. If the next access targets the same row, only a new column strobe is issued. An access to a different row first closes the open row. The row strobe then stays high for the precharge interval before the full row-then-column sequence runs again. A refresh agent can ask for the array through `ref_req`. The sequencer closes the open row, precharges, and holds `ref_gnt` high until the request is withdrawn. Host requests are refused during that time.

The full address is split with the row taken from the upper bits and the column from the lower bits. With the defaults (9 row bits, 9 column bits, 4 ns clock) the cycle counts are as follows:

| Timing | Cycles |
|---|---|
| Row access time | 15 |
| Column access time | 4 |
| Row-to-column delay | 5 |
| Precharge | 10 |

Top module: `dram_seq`

## Requirements
- R1: After reset `ras_n`, `cas_n` and `we_n` are high, `dq_oe` and `done` are low, `ref_gnt` is low and `req_ready` is high.
- R2: When `ras_n` falls, `dram_addr` carries `req_addr[ADDR_W-1:COL_W]` (the row). When `cas_n` falls, `dram_addr` carries `req_addr[COL_W-1:0]` (the column). The column address stays stable while `cas_n` is low. `cas_n` only falls while `ras_n` is already low, and `ras_n` only falls while `cas_n` is high.
- R3: For a read, `rd_data` is sampled from `dq_in` no earlier than TRAC cycles after `ras_n` fell and no earlier than TCAC cycles after `cas_n` fell. `rd_data` holds the word stored at that address while `done` is high.
- R4: For a write, `we_n` is low and `dq_oe` is high with `dq_out` equal to the write data from the cycle before `cas_n` falls until `cas_n` rises.
- R5: An accepted request whose row equals the open row causes no `ras_n` fall. `done` rises TCAC+1 = 5 cycles after the accepting edge.
- R6: With no row open and precharge satisfied, `done` rises TRCD+W+2 = 16 cycles after the accepting edge, where W = max(TCAC, TRAC-TRCD-1) = 9.
- R7: A request to a different row raises `ras_n`. `ras_n` then stays high for at least TRP cycles before it falls again. `done` rises TRP+TRCD+W+2 = 26 cycles after the accepting edge.
- R8: While `ref_req` is high, `req_ready` is low and no host request is accepted. The open row is closed, and `ref_gnt` rises only after `ras_n` has been high for TRP cycles. While `ref_gnt` is high, `ras_n` and `cas_n` stay high.
- R9: The first access after a refresh ends runs the full row-then-column sequence with the R6 latency.
- R10: `done` is high for exactly one cycle per accepted request and never on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Full address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid with done |
| done | output | 1 | One-cycle completion pulse |
| ref_req | input | 1 | Refresh agent wants the array |
| ref_gnt | output | 1 | Row closed and precharged, array handed over |
| dram_addr | output | PIN_W | Shared row/column address pins |
| ras_n | output | 1 | Active-low row strobe |
| cas_n | output | 1 | Active-low column strobe |
| we_n | output | 1 | Active-low write enable |
| dq_out | output | DATA_W | Write data to the DRAM |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | DATA_W | Read data from the DRAM |

## Verification
Every result has a fixed latency counted from the edge that accepts the request: a page hit completes after 5 cycles, an access with no row open after 16, and a row miss after 26. The refresh grant follows the row close after the 10-cycle precharge. The driver records the accepting edge with each expected item in the scoreboard queue. The monitor pops an item when `done` is seen at a falling clock edge and compares both the elapsed cycle count and the data. The memory model in the bench only returns the stored word once both the row and the column strobe have been low for their access times, and it returns a poison word otherwise. An early capture therefore shows up as a data mismatch instead of a timing guess.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECH,
        ST_ROW_SET,
        ST_RAS_WAIT,
        ST_COL_SET,
        ST_CAS_WAIT,
        ST_REF_PRE,
        ST_REF_GNT
    } seq_state_e;

    typedef enum logic {
        PH_ROW,
        PH_COL
    } addr_phase_e;

    // Round a nanosecond figure up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
    parameter int ROW_W = 9,
    parameter int COL_W = 9,
    parameter int PIN_W = 9
) (
    input  logic [ROW_W+COL_W-1:0]   cur_addr,
    input  logic [ROW_W+COL_W-1:0]   new_addr,
    input  logic [ROW_W-1:0]         open_row,
    input  dram_seq_pkg::addr_phase_e phase,
    output logic [PIN_W-1:0]         pin_addr,
    output logic                     row_hit,
    output logic [ROW_W-1:0]         cur_row
);
    localparam int ADDR_W = ROW_W + COL_W;

    logic [PIN_W-1:0] row_pad;
    logic [PIN_W-1:0] col_pad;

    assign cur_row = cur_addr[ADDR_W-1:COL_W];
    assign row_hit = (new_addr[ADDR_W-1:COL_W] == open_row);

    generate
        if (ROW_W < PIN_W) begin : g_row_pad
            assign row_pad = {{(PIN_W-ROW_W){1'b0}}, cur_addr[ADDR_W-1:COL_W]};
        end else begin : g_row_full
            assign row_pad = cur_addr[ADDR_W-1:COL_W];
        end
        if (COL_W < PIN_W) begin : g_col_pad
            assign col_pad = {{(PIN_W-COL_W){1'b0}}, cur_addr[COL_W-1:0]};
        end else begin : g_col_full
            assign col_pad = cur_addr[COL_W-1:0];
        end
    endgenerate

    assign pin_addr = (phase == dram_seq_pkg::PH_COL) ? col_pad : row_pad;

endmodule

// File: rtl/dram_wait_timer.sv
module dram_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/dram_pre_age.sv
module dram_pre_age #(
    parameter int LIMIT = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic ras_n,
    output logic pre_ok
);
    localparam int AW = $clog2(LIMIT + 2);
    localparam logic [AW-1:0] LIM = AW'(LIMIT);

    logic [AW-1:0] age;

    // Cycles the row strobe has been high, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (rst) begin
            age <= LIM;
        end else if (!ras_n) begin
            age <= '0;
        end else if (age < LIM) begin
            age <= age + 1'b1;
        end
    end

    assign pre_ok = (age >= LIM);

endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_seq_pkg::*;
#(
    parameter int ROW_W   = 9,
    parameter int COL_W   = 9,
    parameter int DATA_W  = 16,
    parameter int CLK_NS  = 4,
    parameter int TRAC_NS = 60,
    parameter int TCAC_NS = 15,
    parameter int TRCD_NS = 20,
    parameter int TRP_NS  = 40
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_we,
    input  logic [ROW_W+COL_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      done,
    input  logic                      ref_req,
    output logic                      ref_gnt,
    output logic [imax(ROW_W,COL_W)-1:0] dram_addr,
    output logic                      ras_n,
    output logic                      cas_n,
    output logic                      we_n,
    output logic [DATA_W-1:0]         dq_out,
    output logic                      dq_oe,
    input  logic [DATA_W-1:0]         dq_in
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int PIN_W  = imax(ROW_W, COL_W);
    localparam int TRAC_C = imax(1, ns_to_cyc(TRAC_NS, CLK_NS));
    localparam int TCAC_C = imax(1, ns_to_cyc(TCAC_NS, CLK_NS));
    localparam int TRCD_C = imax(1, ns_to_cyc(TRCD_NS, CLK_NS));
    localparam int TRP_C  = imax(1, ns_to_cyc(TRP_NS, CLK_NS));
    // Column wait after a fresh row must also cover the row access budget.
    localparam int W_FULL = imax(TCAC_C, TRAC_C - TRCD_C - 1);
    localparam int W_HIT  = TCAC_C;
    localparam int CNT_W  = $clog2(imax(W_FULL, TRCD_C) + 1);
    localparam logic [CNT_W-1:0] LD_RCD  = CNT_W'(TRCD_C - 1);
    localparam logic [CNT_W-1:0] LD_FULL = CNT_W'(W_FULL - 1);
    localparam logic [CNT_W-1:0] LD_HIT  = CNT_W'(W_HIT - 1);

    seq_state_e        state, state_n;
    logic              we_q;
    logic              hit_q;
    logic              row_open;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ROW_W-1:0]  row_q;
    logic [ROW_W-1:0]  cur_row;
    logic              row_hit;
    logic              pre_ok;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic              accept;
    addr_phase_e       phase;

    dram_addr_mux #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .PIN_W (PIN_W)
    ) u_mux (
        .cur_addr (addr_q),
        .new_addr (req_addr),
        .open_row (row_q),
        .phase    (phase),
        .pin_addr (dram_addr),
        .row_hit  (row_hit),
        .cur_row  (cur_row)
    );

    dram_wait_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    dram_pre_age #(
        .LIMIT (TRP_C - 1)
    ) u_pre (
        .clk    (clk),
        .rst    (rst),
        .ras_n  (ras_n),
        .pre_ok (pre_ok)
    );

    // Pin decode from the registered state.
    always_comb begin
        ras_n = !((state == ST_RAS_WAIT) || (state == ST_COL_SET) ||
                  (state == ST_CAS_WAIT) || ((state == ST_IDLE) && row_open));
        cas_n = (state != ST_CAS_WAIT);
        dq_oe = ((state == ST_COL_SET) || (state == ST_CAS_WAIT)) && we_q;
        we_n  = !dq_oe;
        phase = ((state == ST_COL_SET) || (state == ST_CAS_WAIT)) ? PH_COL : PH_ROW;
    end

    assign dq_out    = wdata_q;
    assign req_ready = (state == ST_IDLE) && !ref_req;
    assign ref_gnt   = (state == ST_REF_GNT);
    assign accept    = req_ready && req_valid;

    always_comb begin
        state_n  = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (ref_req) begin
                    state_n = ST_REF_PRE;
                end else if (req_valid) begin
                    if (row_open && row_hit) begin
                        state_n = ST_COL_SET;
                    end else if (row_open || !pre_ok) begin
                        state_n = ST_PRECH;
                    end else begin
                        state_n = ST_ROW_SET;
                    end
                end
            end
            ST_PRECH: begin
                if (pre_ok) state_n = ST_ROW_SET;
            end
            ST_ROW_SET: begin
                state_n  = ST_RAS_WAIT;
                tmr_load = 1'b1;
                tmr_val  = LD_RCD;
            end
            ST_RAS_WAIT: begin
                if (tmr_exp) state_n = ST_COL_SET;
            end
            ST_COL_SET: begin
                state_n  = ST_CAS_WAIT;
                tmr_load = 1'b1;
                tmr_val  = hit_q ? LD_HIT : LD_FULL;
            end
            ST_CAS_WAIT: begin
                if (tmr_exp) state_n = ST_IDLE;
            end
            ST_REF_PRE: begin
                if (pre_ok) state_n = ST_REF_GNT;
            end
            ST_REF_GNT: begin
                if (!ref_req) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            we_q     <= 1'b0;
            hit_q    <= 1'b0;
            row_open <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            row_q    <= '0;
            rd_data  <= '0;
            done     <= 1'b0;
        end else begin
            state <= state_n;
            done  <= 1'b0;
            if (accept) begin
                we_q    <= req_we;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                hit_q   <= row_open && row_hit;
            end
            if ((state == ST_IDLE) && (state_n == ST_PRECH || state_n == ST_REF_PRE)) begin
                row_open <= 1'b0;
            end
            if (state == ST_ROW_SET) begin
                row_open <= 1'b1;
                row_q    <= cur_row;
            end
            if ((state == ST_CAS_WAIT) && tmr_exp) begin
                done <= 1'b1;
                if (!we_q) rd_data <= dq_in;
            end
        end
    end

endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
    parameter int PIN_W = 9,
    parameter int TRP_C = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             dq_oe,
    input logic             done,
    input logic             req_ready,
    input logic             ref_gnt,
    input logic [PIN_W-1:0] dram_addr
);
    localparam int HW = $clog2(TRP_C + 2);
    localparam logic [HW-1:0] HLIM = HW'(TRP_C);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= HLIM;
        end else if (!ras_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt < HLIM) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_cas_under_ras_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> !ras_n);

    assert_ras_fall_cas_high_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> cas_n);

    assert_col_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!cas_n && !$past(cas_n)) |-> $stable(dram_addr));

    assert_precharge_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (hi_cnt >= HLIM));

    assert_refresh_pins_R8: assert property (@(posedge clk) disable iff (rst)
        ref_gnt |-> (ras_n && cas_n && !req_ready));

    assert_write_drive_R4: assert property (@(posedge clk) disable iff (rst)
        (!cas_n && !we_n) |-> dq_oe);

endmodule

bind dram_seq dram_seq_chk #(
    .PIN_W (PIN_W),
    .TRP_C (TRP_C)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .dq_oe     (dq_oe),
    .done      (done),
    .req_ready (req_ready),
    .ref_gnt   (ref_gnt),
    .dram_addr (dram_addr)
);

// File: tb/tb_dram_seq.sv
module tb_dram_seq;
    localparam int ROW_W = 9;
    localparam int COL_W = 9;
    localparam int ADDR_W = 18;
    localparam int DATA_W = 16;
    // Cycle figures at 4 ns: 60/15/20/40 ns.
    localparam int TRAC = 15;
    localparam int TCAC = 4;
    localparam int TRCD = 5;
    localparam int TRP  = 10;
    localparam int W_FULL   = 9;
    localparam int LAT_HIT  = TCAC + 1;
    localparam int LAT_FULL = TRCD + W_FULL + 2;
    localparam int LAT_MISS = TRP + LAT_FULL;
    localparam logic [15:0] POISON = 16'hDEAD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [DATA_W-1:0] rd_data;
    logic done;
    logic ref_req = 1'b0;
    logic ref_gnt;
    logic [8:0] dram_addr;
    logic ras_n, cas_n, we_n, dq_oe;
    logic [DATA_W-1:0] dq_out;
    logic [DATA_W-1:0] dq_in = '0;

    always #2 clk = ~clk;

    dram_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .done(done), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_issued = 0;
    int n_done = 0;
    int ras_falls = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural DRAM: latches row/col on strobe falls, returns poison until both access times elapse.
    logic [15:0] mdl [int];
    int ras_age = 0, cas_age = 0, hi_age = TRP;
    logic prev_ras = 1'b1, prev_cas = 1'b1;
    logic [8:0] m_row = '0, m_col = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_ras && !ras_n) begin
                ras_falls++;
                chk(hi_age >= TRP, "R7", "precharge cycles before row strobe", hi_age, TRP);
                m_row = dram_addr;
            end
            if (prev_cas && !cas_n) begin
                chk(!ras_n, "R2", "row strobe low at column strobe", ras_n, 0);
                m_col = dram_addr;
                if (!we_n) begin
                    chk(dq_oe, "R4", "data driven at write strobe", dq_oe, 1);
                    mdl[int'({m_row, m_col})] = dq_out;
                end
            end
            ras_age = ras_n ? 0 : ras_age + 1;
            cas_age = cas_n ? 0 : cas_age + 1;
            hi_age  = ras_n ? hi_age + 1 : 0;
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
        if (!cas_n && ras_age >= TRAC && cas_age >= TCAC)
            dq_in = mdl.exists(int'({m_row, m_col})) ? mdl[int'({m_row, m_col})] : 16'h0000;
        else
            dq_in = POISON;
    end

    // Scoreboard
    typedef struct {
        bit          we;
        logic [15:0] data;
        int          lat;
        int          acc;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];
    logic [15:0] shadow [int];
    logic prev_done = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (done && prev_done)
                chk(1'b0, "R10", "done on consecutive cycles", 1, 0);
            if (done) begin
                n_done++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R10", "done without pending request", 1, 0);
                end else begin
                    sb_item_t it;
                    it = sb.pop_front();
                    chk((cyc - it.acc) == it.lat, it.tag, "done latency", cyc - it.acc, it.lat);
                    if (!it.we)
                        chk(rd_data == it.data, "R3", "read data", rd_data, it.data);
                end
            end
            prev_done = done;
        end
    end

    function automatic logic [ADDR_W-1:0] mk(input int r, input int c);
        return {r[8:0], c[8:0]};
    endfunction

    task automatic access(input bit we, input logic [ADDR_W-1:0] a,
                          input logic [15:0] d, input int lat, input string tag);
        sb_item_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        it.we  = we;
        it.lat = lat;
        it.acc = cyc + 1;
        it.tag = tag;
        if (we) begin
            shadow[int'(a)] = d;
            it.data = d;
        end else begin
            it.data = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        end
        sb.push_back(it);
        n_issued++;
        @(negedge clk);
        req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int rf;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ras_n && cas_n && we_n, "R1", "strobes high", {ras_n, cas_n, we_n}, 3'b111);
        chk(!done && !dq_oe && !ref_gnt, "R1", "done/oe/gnt low", {done, dq_oe, ref_gnt}, 0);
        chk(req_ready, "R1", "ready high", req_ready, 1);

        // R6 cold write, R4 write path
        access(1'b1, mk(5, 3), 16'hBEEF, LAT_FULL, "R6");
        rf = ras_falls;
        // R5 page hits
        access(1'b1, mk(5, 7), 16'h1234, LAT_HIT, "R5");
        access(1'b0, mk(5, 3), 16'h0, LAT_HIT, "R5");
        chk(ras_falls == rf, "R5", "no row strobe on page hits", ras_falls, rf);
        // R7 row miss, unwritten word
        access(1'b0, mk(9, 3), 16'h0, LAT_MISS, "R7");
        chk(ras_falls == rf + 1, "R7", "one new row strobe", ras_falls, rf + 1);
        access(1'b1, mk(9, 3), 16'h5A5A, LAT_HIT, "R5");
        access(1'b0, mk(9, 3), 16'h0, LAT_HIT, "R3");
        // R2 address split checked through data from another row
        access(1'b0, mk(5, 7), 16'h0, LAT_MISS, "R2");

        // R8 refresh with a competing host request
        @(negedge clk);
        ref_req   = 1'b1;
        req_valid = 1'b1;
        req_we    = 1'b0;
        req_addr  = mk(1, 1);
        @(negedge clk);
        chk(!req_ready, "R8", "ready low during refresh request", req_ready, 0);
        for (int i = 0; i < 50 && !ref_gnt; i++) @(negedge clk);
        chk(ref_gnt, "R8", "grant raised", ref_gnt, 1);
        chk(hi_age >= TRP, "R8", "precharge before grant", hi_age, TRP);
        rf = ras_falls;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(ras_n && cas_n && !req_ready, "R8", "pins idle while granted",
                {ras_n, cas_n, req_ready}, 3'b110);
        end
        chk(ras_falls == rf && n_done == n_issued, "R8", "no access during grant",
            n_done, n_issued);
        req_valid = 1'b0;
        ref_req   = 1'b0;
        @(negedge clk);
        chk(!ref_gnt, "R8", "grant released", ref_gnt, 0);

        // R9 full sequence after refresh
        access(1'b0, mk(5, 7), 16'h0, LAT_FULL, "R9");

        // Address boundaries
        access(1'b1, mk(511, 511), 16'hFFFF, LAT_MISS, "R7");
        access(1'b0, mk(0, 0), 16'h0, LAT_MISS, "R2");
        access(1'b1, mk(0, 511), 16'h0F0F, LAT_HIT, "R5");
        access(1'b0, mk(511, 511), 16'h0, LAT_MISS, "R2");
        access(1'b0, mk(0, 511), 16'h0, LAT_MISS, "R3");

        repeat (3) @(negedge clk);
        chk(n_done == n_issued, "R10", "one done per request", n_done, n_issued);
        finish_run();
    end

endmodule